// File: doc/BRIEF.md
# Software Write-Protect Sequence Guard

This block sits in front of a byte-wide nonvolatile memory array and screens every byte write headed for storage. The address space is cut into equal blocks, and each block has its own protect flag. While a block's flag is clear, writes to it pass straight through. While the flag is set, a write reaches storage only when the same programming period has already seen a three-byte unlock prefix written to that block. The flags are changed only by exact address/data command sequences. A three-byte prefix arms the flag to set, and a six-byte sequence arms it to clear. An armed change takes effect when the current programming period ends.

Writes arrive on a valid/ready stream. A write is accepted on a clock edge where `wr_valid` and `wr_ready` are both high. The sender must hold `wr_addr` and `wr_data` stable while `wr_valid` is high and `wr_ready` is low. The guard drops `wr_ready` while the external programming timer reports a period in progress (`prog_busy`), and for one further cycle after `prog_busy` falls; it is never low at any other time.

Every accepted write produces a one-cycle result pulse on the next edge. The pulse gives the pass/suppress decision and a timer-start request. The timer request is raised even for a suppressed write, so a blocked write looks busy to the host. The result side is a fixed-latency sideband with no ready.

The flags model nonvolatile bits. They power up clear and are never touched by `rst`. Reset only returns the sequence matchers to idle.

Top module: `wp_seq_guard`

## Requirements
- R1: `wr_ready` is low whenever `prog_busy` is high. It is also low in the one cycle after `prog_busy` falls, and high otherwise.
- R2: A write accepted at edge k produces `res_valid` and `tmr_start` high for exactly the cycle after edge k, with `res_blk` giving its block. No result appears without an accepted write.
- R3: A write to a block whose flag is clear always commits (`res_commit` = 1).
- R4: A write to a protected block that is not preceded by the unlock prefix is suppressed (`res_commit` = 0), and its `tmr_start` pulse is still raised.
- R5: The unlock prefix, by block offset (the low 17 address bits), is: data 0xAA at offset 0x05555, then 0x55 at 0x02AAA, then 0xA0 at 0x05555. While the block is protected, the prefix bytes themselves are suppressed. Every later write to that block in the same period commits.
- R6: At the end of a period in which a block's unlock prefix completed, that block's flag becomes 1, even if no data byte followed. The flag changes on the edge where `prog_busy` is sampled low after having been high.
- R7: The six-byte sequence 0xAA@0x05555, 0x55@0x02AAA, 0x80@0x05555, 0xAA@0x05555, 0x55@0x02AAA, 0x20@0x05555 clears the block's flag at the end of the period. Writes to the block that follow the sequence in the same period commit.
- R8: A write that does not match the next expected step sends that block's matcher to idle and is handled as an ordinary write.
- R9: The end of every period returns all matchers to idle, so a protected block needs a fresh prefix in each period.
- R10: The block index is the address bits above the 17-bit offset. Each block's matcher and flag respond only to writes addressed to that block.
- R11: All flags power up clear. `rst` returns the matchers to idle and leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (matchers and result only) |
| wr_valid | input | 1 | Write transaction offered |
| wr_ready | output | 1 | Guard can accept a write |
| wr_addr | input | AW (19) | Byte address: block index above a 17-bit offset |
| wr_data | input | 8 | Byte to write |
| prog_busy | input | 1 | High while the programming period runs; its fall ends the period |
| res_valid | output | 1 | One-cycle result pulse for an accepted write |
| res_commit | output | 1 | 1 = pass the write to storage, 0 = suppress it |
| res_blk | output | AW-17 (2) | Block index of the resulting write |
| tmr_start | output | 1 | Request to start the write timer |
| prot_o | output | 2**(AW-17) (4) | Per-block protect flags |

## Verification
A decision is due exactly one edge after acceptance. The bench therefore drives a write on a falling edge and reads the result at the next falling edge. A flag change is due on the edge that samples `prog_busy` low after it was high. The bench drops `prog_busy` on a falling edge and reads `prot_o` one falling edge later. `wr_ready` follows `prog_busy` combinationally and is then held low for one registered cycle. The bench checks it both while the period runs and right after `prog_busy` drops, before that edge.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_C1,
    SQ_C2,
    SQ_OPEN_EN,
    SQ_D3,
    SQ_D4,
    SQ_D5,
    SQ_OPEN_DIS
  } seq_e;

  localparam logic [16:0] CMD_OFS_A = 17'h05555;
  localparam logic [16:0] CMD_OFS_B = 17'h02AAA;
  localparam logic [7:0]  KEY_1     = 8'hAA;
  localparam logic [7:0]  KEY_2     = 8'h55;
  localparam logic [7:0]  KEY_EN    = 8'hA0;
  localparam logic [7:0]  KEY_DIS   = 8'h80;
  localparam logic [7:0]  KEY_DEND  = 8'h20;
endpackage

// File: rtl/wp_seq_match.sv
module wp_seq_match
  import wp_pkg::*;
#(
  parameter int unsigned OW = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic [OW-1:0]     offs,
  input  logic [BYTE_W-1:0] data,
  input  logic              period_end,
  output logic              window_o,
  output logic              arm_en_o,
  output logic              arm_dis_o
);
  seq_e st_q, st_d;
  logic at_a, at_b;

  assign at_a = (offs == OW'(CMD_OFS_A));
  assign at_b = (offs == OW'(CMD_OFS_B));

  always_comb begin
    st_d = st_q;
    if (period_end) begin
      st_d = SQ_IDLE;
    end else if (hit) begin
      unique case (st_q)
        SQ_IDLE: st_d = (at_a && data == KEY_1) ? SQ_C1 : SQ_IDLE;
        SQ_C1:   st_d = (at_b && data == KEY_2) ? SQ_C2 : SQ_IDLE;
        SQ_C2: begin
          if (at_a && data == KEY_EN)       st_d = SQ_OPEN_EN;
          else if (at_a && data == KEY_DIS) st_d = SQ_D3;
          else                              st_d = SQ_IDLE;
        end
        SQ_D3:   st_d = (at_a && data == KEY_1) ? SQ_D4 : SQ_IDLE;
        SQ_D4:   st_d = (at_b && data == KEY_2) ? SQ_D5 : SQ_IDLE;
        SQ_D5:   st_d = (at_a && data == KEY_DEND) ? SQ_OPEN_DIS : SQ_IDLE;
        SQ_OPEN_EN, SQ_OPEN_DIS: st_d = st_q;
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= SQ_IDLE;
    else     st_q <= st_d;
  end

  assign window_o  = (st_q == SQ_OPEN_EN) || (st_q == SQ_OPEN_DIS);
  assign arm_en_o  = (st_q == SQ_OPEN_EN);
  assign arm_dis_o = (st_q == SQ_OPEN_DIS);
endmodule

// File: rtl/wp_flag_cell.sv
module wp_flag_cell (
  input  logic clk,
  input  logic period_end,
  input  logic arm_en,
  input  logic arm_dis,
  output logic flag_o
);
  // Nonvolatile bit: initial value only, never reset.
  logic flag_q = 1'b0;

  always_ff @(posedge clk) begin
    if (period_end) begin
      if (arm_en)       flag_q <= 1'b1;
      else if (arm_dis) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/wp_seq_guard.sv
module wp_seq_guard
  import wp_pkg::*;
#(
  parameter int unsigned AW = 19,
  parameter int unsigned OW = 17
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_valid,
  output logic                     wr_ready,
  input  logic [AW-1:0]            wr_addr,
  input  logic [BYTE_W-1:0]        wr_data,
  input  logic                     prog_busy,
  output logic                     res_valid,
  output logic                     res_commit,
  output logic [AW-OW-1:0]         res_blk,
  output logic                     tmr_start,
  output logic [(1<<(AW-OW))-1:0]  prot_o
);
  localparam int unsigned BW   = AW - OW;
  localparam int unsigned NBLK = 1 << BW;

  logic            busy_q;
  logic            period_end;
  logic            accept;
  logic [BW-1:0]   blk;
  logic [NBLK-1:0] window, arm_en, arm_dis, prot;

  always_ff @(posedge clk) begin
    if (rst) busy_q <= 1'b0;
    else     busy_q <= prog_busy;
  end

  assign period_end = busy_q && !prog_busy;
  assign wr_ready   = !prog_busy && !busy_q;
  assign accept     = wr_valid && wr_ready;
  assign blk        = wr_addr[AW-1:OW];

  for (genvar i = 0; i < NBLK; i++) begin : g_blk
    wp_seq_match #(.OW(OW)) u_match (
      .clk        (clk),
      .rst        (rst),
      .hit        (accept && (blk == BW'(i))),
      .offs       (wr_addr[OW-1:0]),
      .data       (wr_data),
      .period_end (period_end),
      .window_o   (window[i]),
      .arm_en_o   (arm_en[i]),
      .arm_dis_o  (arm_dis[i])
    );
    wp_flag_cell u_flag (
      .clk        (clk),
      .period_end (period_end),
      .arm_en     (arm_en[i]),
      .arm_dis    (arm_dis[i]),
      .flag_o     (prot[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_commit <= 1'b0;
      res_blk    <= '0;
      tmr_start  <= 1'b0;
    end else begin
      res_valid  <= accept;
      tmr_start  <= accept;
      res_commit <= accept && (!prot[blk] || window[blk]);
      res_blk    <= accept ? blk : res_blk;
    end
  end

  assign prot_o = prot;
endmodule

// File: rtl/wp_seq_guard_chk.sv
module wp_seq_guard_chk #(
  parameter int unsigned AW = 19,
  parameter int unsigned OW = 17
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    wr_valid,
  input logic                    wr_ready,
  input logic                    prog_busy,
  input logic                    res_valid,
  input logic                    res_commit,
  input logic [AW-OW-1:0]        res_blk,
  input logic [(1<<(AW-OW))-1:0] prot_o
);
  // R1
  ready_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
    prog_busy |-> !wr_ready);

  // R2
  res_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (res_valid == $past(wr_valid && wr_ready && !rst)));

  // R3
  open_block_commits_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !prot_o[res_blk]) |-> res_commit);

  // R6
  prot_change_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    (prot_o != $past(prot_o)) |-> ($past(prog_busy, 2) && !$past(prog_busy)));
endmodule

bind wp_seq_guard wp_seq_guard_chk #(.AW(AW), .OW(OW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .prog_busy  (prog_busy),
  .res_valid  (res_valid),
  .res_commit (res_commit),
  .res_blk    (res_blk),
  .prot_o     (prot_o)
);

// File: tb/sim_wp_seq_guard.sv
`timescale 1ns/1ps
module sim_wp_seq_guard;
  localparam int AW = 19;
  localparam int OW = 17;
  localparam int NV = 33;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic prog_busy = 1'b0;
  logic res_valid, res_commit, tmr_start;
  logic [1:0] res_blk;
  logic [3:0] prot_o;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  wp_seq_guard #(.AW(AW), .OW(OW)) u0 (.*);

  // {op(1: end of period), expect(4), addr(19), data(8)}
  // write: expect[0] = commit; end: expect = flags afterwards
  localparam logic [31:0] VEC [NV] = '{
    {1'b0, 4'd1, 19'h05555, 8'hAA}, {1'b0, 4'd1, 19'h02AAA, 8'h55},
    {1'b0, 4'd1, 19'h05555, 8'hA0}, {1'b0, 4'd1, 19'h00100, 8'h11},
    {1'b1, 4'd1, 19'h0,     8'h0 }, {1'b0, 4'd0, 19'h00200, 8'h22},
    {1'b1, 4'd1, 19'h0,     8'h0 }, {1'b0, 4'd0, 19'h05555, 8'hAA},
    {1'b0, 4'd0, 19'h02AAA, 8'h55}, {1'b0, 4'd0, 19'h05555, 8'hA0},
    {1'b0, 4'd1, 19'h00300, 8'h33}, {1'b0, 4'd1, 19'h00301, 8'h34},
    {1'b1, 4'd1, 19'h0,     8'h0 }, {1'b0, 4'd1, 19'h20000, 8'h44},
    {1'b0, 4'd1, 19'h25555, 8'hAA}, {1'b0, 4'd1, 19'h22AAA, 8'h55},
    {1'b0, 4'd1, 19'h25555, 8'hA0}, {1'b1, 4'd3, 19'h0,     8'h0 },
    {1'b0, 4'd0, 19'h05555, 8'hAA}, {1'b0, 4'd0, 19'h02AAA, 8'h56},
    {1'b0, 4'd0, 19'h05555, 8'hA0}, {1'b0, 4'd0, 19'h00400, 8'h45},
    {1'b1, 4'd3, 19'h0,     8'h0 }, {1'b0, 4'd0, 19'h05555, 8'hAA},
    {1'b0, 4'd0, 19'h02AAA, 8'h55}, {1'b0, 4'd0, 19'h05555, 8'h80},
    {1'b0, 4'd0, 19'h05555, 8'hAA}, {1'b0, 4'd0, 19'h02AAA, 8'h55},
    {1'b0, 4'd0, 19'h05555, 8'h20}, {1'b0, 4'd1, 19'h00500, 8'h66},
    {1'b1, 4'd2, 19'h0,     8'h0 }, {1'b0, 4'd1, 19'h00600, 8'h77},
    {1'b1, 4'd2, 19'h0,     8'h0 }
  };

  function automatic string tag_of(int i);
    if (i <= 3)  return "R3";
    if (i == 4)  return "R6";
    if (i == 5)  return "R4";
    if (i == 6)  return "R9";
    if (i <= 11) return "R5";
    if (i == 12) return "R9";
    if (i <= 16) return "R10";
    if (i == 17) return "R6";
    if (i <= 22) return "R8";
    return "R7";
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d,
                          input bit expc, input string req);
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    check(res_valid && tmr_start, "R2", {res_valid, tmr_start}, 3);
    check(res_blk == a[AW-1:OW], "R10", res_blk, a[AW-1:OW]);
    check(res_commit == expc, req, res_commit, expc);
  endtask

  task automatic do_end(input logic [3:0] expp, input string req);
    @(negedge clk);
    prog_busy = 1'b1;
    @(negedge clk);
    check(!wr_ready, "R1", wr_ready, 0);
    prog_busy = 1'b0;
    #1;
    check(!wr_ready, "R1", wr_ready, 0);
    @(negedge clk);
    check(wr_ready, "R1", wr_ready, 1);
    check(prot_o == expp, req, prot_o, expp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: flags power up clear; idle outputs after reset
    check(prot_o == 4'h0, "R11", prot_o, 0);
    check(!res_valid && !tmr_start, "R2", {res_valid, tmr_start}, 0);
    check(wr_ready, "R1", wr_ready, 1);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][31]) do_end(VEC[i][30:27], tag_of(i));
      else do_write(VEC[i][26:8], VEC[i][7:0], VEC[i][27], tag_of(i));
    end

    // R11: reset mid-sequence on protected block 1 keeps the flag, idles the matcher
    do_write(19'h25555, 8'hAA, 1'b0, "R4");
    do_write(19'h22AAA, 8'h55, 1'b0, "R4");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(prot_o == 4'h2, "R11", prot_o, 2);
    check(!res_valid, "R2", res_valid, 0);
    do_write(19'h25555, 8'hA0, 1'b0, "R11");
    do_write(19'h21000, 8'h99, 1'b0, "R11");
    do_end(4'h2, "R11");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule